// File: doc/BRIEF.md
# Memory-Driven Video Scanout Engine

This block is the free-running display side of a frame store that keeps the whole video waveform in memory, sync pulses included. Each memory byte is one dot-clock period of output. A 19-bit address counter advances on every dot clock. The byte at the current address is caught in a pixel register on the same edge, and that register is split into a horizontal sync bit, a vertical sync bit and three 2-bit colour channels.

The counter has no terminal count. A frame repeats only because of a rising edge on the captured vertical sync bit. A second register stage holds the previous captured value, and the edge is found by comparing the two. The edge clears the counter synchronously on the following dot-clock edge. This leaves one extra byte, a delay slot, after the edge byte. If the edge byte sits at address A, the frame is A+2 bytes long, and software lays out the image with that offset in mind.

A load-mode input gives the counter to a host port. In load mode the host clears the address, steps it one position at a time and writes bytes. The pixel register holds an idle pattern during load mode. The memory model is a synchronous-write byte array that stores 2**MEM_AW bytes and aliases the higher address bits.

Top module: `scan_engine`

## Requirements
- R1: After reset the address is 0, both sync outputs are 1 and all colour outputs are 0.
- R2: In run mode, unless a clear is pending, the address rises by exactly one on every dot-clock edge. The pixel register captures the byte at the pre-edge address on that same edge.
- R3: The captured byte is decoded as follows: bit 7 is vertical sync, bit 6 is horizontal sync, bits 5:4 are red, bits 3:2 are green and bits 1:0 are blue.
- R4: When the captured vertical sync is 1 and its previously captured value is 0, the address becomes 0 on the next dot-clock edge. A frame whose edge byte sits at address A therefore repeats every A+2 clocks.
- R5: While the captured vertical sync stays at 1 or stays at 0, the address is never cleared.
- R6: In any cycle after a load-mode edge, both sync outputs are 1 and all colours are 0, whatever the memory holds.
- R7: In load mode, host_clr clears the address on the next edge and has priority over host_step. host_step alone adds one to the address. With neither asserted, the address holds.
- R8: In load mode, host_we writes host_wdata into the current address on the clock edge, whether or not the address also steps.
- R9: The edge-detect history is preset to 1 by every load-mode cycle. The first run-mode cycle after load mode therefore never clears the address, even if the last vertical sync seen before load mode was 0.
- R10: In run mode, host_clr, host_step and host_we have no effect on the address or on the memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_mode | input | 1 | 1 gives the counter and memory to the host port |
| host_clr | input | 1 | Host synchronous address clear (load mode) |
| host_step | input | 1 | Host address increment (load mode) |
| host_we | input | 1 | Host memory write strobe (load mode) |
| host_wdata | input | 8 | Host write byte |
| addr | output | 19 | Current scan address |
| vsync | output | 1 | Captured vertical sync |
| hsync | output | 1 | Captured horizontal sync |
| red | output | 2 | Red channel |
| green | output | 2 | Green channel |
| blue | output | 2 | Blue channel |

## Verification
A 12-byte frame is written through the host port. It has a long high stretch of vertical sync, a two-byte low pulse, an edge byte at address 10 and a delay-slot byte. Three back-to-back run frames separate a correct A+2 period from a level-triggered clear and from an early or late clear. Each byte has a different colour, so any swap of field positions shows up. Run-mode passes with every host strobe asserted show whether the host port leaks into run mode. A one-cycle load entered while vertical sync is low shows whether the edge history is preset. A patched byte, written without stepping, checks the write address.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int ADDR_W   = 19;
  localparam int DATA_W   = 8;
  localparam int CH_W     = 2;
  localparam int VS_BIT   = 7;
  localparam int HS_BIT   = 6;
  localparam int R_LSB    = 4;
  localparam int G_LSB    = 2;
  localparam int B_LSB    = 0;
  localparam int NUM_CH   = 3;

  // sync lines idle high, colour black
  localparam logic [DATA_W-1:0] IDLE_BYTE = 8'hC0;

  typedef struct packed {
    logic            vs;
    logic            hs;
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } pix_t;

  function automatic pix_t unpack_pix(input logic [DATA_W-1:0] byte_in);
    pix_t p;
    p.vs = byte_in[VS_BIT];
    p.hs = byte_in[HS_BIT];
    p.r  = byte_in[R_LSB +: CH_W];
    p.g  = byte_in[G_LSB +: CH_W];
    p.b  = byte_in[B_LSB +: CH_W];
    return p;
  endfunction

  function automatic logic edge_up(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction
endpackage

// File: rtl/scan_addr_ctr.sv
module scan_addr_ctr #(
  parameter int AW = scan_pkg::ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [AW-1:0] addr
);
  function automatic logic [AW-1:0] next_addr(input logic c, input logic i,
                                               input logic [AW-1:0] cur);
    if (c)      return '0;
    else if (i) return cur + AW'(1);
    else        return cur;
  endfunction

  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= next_addr(clr, inc, addr_q);
  end

  assign addr = addr_q;

  // R7
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (addr == '0));
  // R2
  inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && inc) |=> (addr == $past(addr) + AW'(1)));
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(addr));
endmodule

// File: rtl/scan_mem.sv
module scan_mem #(
  parameter int MEM_AW = 10,
  parameter int DW     = scan_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [MEM_AW-1:0] waddr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  // read path is combinational; the pixel register does the capture
  assign rdata = store[waddr];
endmodule

// File: rtl/scan_pix_reg.sv
module scan_pix_reg #(
  parameter int DW = scan_pkg::DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_idle,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n || hold_idle) q <= scan_pkg::IDLE_BYTE;
    else                     q <= din;
  end

  // R6
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_idle |=> (q == scan_pkg::IDLE_BYTE));
endmodule

// File: rtl/scan_vs_edge.sv
module scan_vs_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic preset,
  input  logic vs_cur,
  output logic rise
);
  logic vs_prev;

  always_ff @(posedge clk) begin
    if (!rst_n || preset) vs_prev <= 1'b1;
    else                  vs_prev <= vs_cur;
  end

  assign rise = scan_pkg::edge_up(vs_cur, vs_prev);

  // R9
  preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    preset |=> !rise);
  // R5
  level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!preset && !rise) |=> (!rise || !$stable(vs_cur)));
endmodule

// File: rtl/scan_engine.sv
module scan_engine #(
  parameter int ADDR_W = scan_pkg::ADDR_W,
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_mode,
  input  logic              host_clr,
  input  logic              host_step,
  input  logic              host_we,
  input  logic [7:0]        host_wdata,
  output logic [ADDR_W-1:0] addr,
  output logic              vsync,
  output logic              hsync,
  output logic [1:0]        red,
  output logic [1:0]        green,
  output logic [1:0]        blue
);
  import scan_pkg::*;

  // named internal events
  logic              vs_rise;
  logic              ctr_clr;
  logic              ctr_inc;
  logic              mem_we;
  logic [DATA_W-1:0] mem_q;
  logic [DATA_W-1:0] pix_q;
  pix_t              pix;

  // run mode: counter free-runs, cleared by captured sync edge
  // load mode: host port owns clear, step and write
  assign ctr_clr = load_mode ? host_clr  : vs_rise;
  assign ctr_inc = load_mode ? host_step : 1'b1;
  assign mem_we  = load_mode & host_we;

  scan_addr_ctr #(.AW(ADDR_W)) u_ctr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (ctr_clr),
    .inc  (ctr_inc),
    .addr (addr)
  );

  scan_mem #(.MEM_AW(MEM_AW), .DW(DATA_W)) u_mem (
    .clk  (clk),
    .we   (mem_we),
    .waddr(addr[MEM_AW-1:0]),
    .wdata(host_wdata),
    .rdata(mem_q)
  );

  scan_pix_reg #(.DW(DATA_W)) u_pix (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_idle(load_mode),
    .din      (mem_q),
    .q        (pix_q)
  );

  assign pix = unpack_pix(pix_q);

  scan_vs_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .preset(load_mode),
    .vs_cur(pix.vs),
    .rise  (vs_rise)
  );

  assign vsync = pix.vs;
  assign hsync = pix.hs;
  assign red   = pix.r;
  assign green = pix.g;
  assign blue  = pix.b;

  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_mode && vs_rise) |=> (addr == '0));
  // R10
  run_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_mode && !vs_rise) |=> (addr == $past(addr) + ADDR_W'(1)));
  // R6
  black_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_mode |=> (red == 2'b00 && green == 2'b00 && blue == 2'b00));
endmodule

// File: tb/sim_scan_engine.sv
module sim_scan_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_mode = 1'b1;
  logic        host_clr = 1'b0;
  logic        host_step = 1'b0;
  logic        host_we = 1'b0;
  logic [7:0]  host_wdata = 8'h00;
  logic [18:0] addr;
  logic        vsync, hsync;
  logic [1:0]  red, green, blue;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] exp_mem [12];
  int   ea;
  logic last_vs;
  logic pend;

  always #10 clk = ~clk;

  scan_engine u0 (
    .clk(clk), .rst_n(rst_n), .load_mode(load_mode),
    .host_clr(host_clr), .host_step(host_step), .host_we(host_we),
    .host_wdata(host_wdata), .addr(addr), .vsync(vsync), .hsync(hsync),
    .red(red), .green(green), .blue(blue)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pix_now();
    return {vsync, hsync, red, green, blue};
  endfunction

  // frame: vsync high except bytes 8,9; edge byte at 10, delay slot 11
  function automatic logic [7:0] frame_byte(input int i);
    logic vs, hs;
    vs = !(i == 8 || i == 9);
    hs = (i != 3);
    return {vs, hs, 6'((i * 7 + 5) & 63)};
  endfunction

  // bench model of one run cycle, then compare
  task automatic run_check(input int n);
    for (int k = 0; k < n; k++) begin
      logic [7:0] np;
      int na;
      bit was_clear;
      np = exp_mem[ea];
      was_clear = pend;
      na = pend ? 0 : ea + 1;
      pend = np[7] & ~last_vs;
      last_vs = np[7];
      ea = na;
      tick();
      check("R3 pixel fields", {24'd0, pix_now()}, {24'd0, np});
      if (was_clear) check("R4 wrap to zero", {13'd0, addr}, na);
      else           check("R2/R5 step by one", {13'd0, addr}, na);
    end
  endtask

  task automatic enter_run_state();
    ea = 0; last_vs = 1'b1; pend = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 addr", {13'd0, addr}, 0);
    check("R1 syncs", {30'd0, vsync, hsync}, 3);
    check("R1 colour", {26'd0, red, green, blue}, 0);
  endtask

  task automatic t_load_frame();
    load_mode = 1'b1;
    host_clr = 1'b1; tick(); host_clr = 1'b0;
    check("R7 host clear", {13'd0, addr}, 0);
    for (int i = 0; i < 12; i++) begin
      exp_mem[i] = frame_byte(i);
      host_wdata = exp_mem[i];
      host_we = 1'b1; host_step = 1'b1;
      tick();
    end
    host_we = 1'b0; host_step = 1'b0;
    check("R7 step count", {13'd0, addr}, 12);
    check("R6 idle in load", {24'd0, pix_now()}, 32'hC0);
    tick();
    check("R7 hold", {13'd0, addr}, 12);
    host_clr = 1'b1; host_step = 1'b1; tick();
    host_clr = 1'b0; host_step = 1'b0;
    check("R7 clear over step", {13'd0, addr}, 0);
  endtask

  task automatic t_run_frames();
    load_mode = 1'b0;
    enter_run_state();
    run_check(36);
    check("R4 period A+2", {13'd0, addr}, 0);
  endtask

  task automatic t_run_ignore();
    host_clr = 1'b1; host_step = 1'b1; host_we = 1'b1; host_wdata = 8'h00;
    run_check(12);
    host_clr = 1'b0; host_step = 1'b0; host_we = 1'b0;
    run_check(12);
    check("R10 memory intact", {13'd0, addr}, 0);
  endtask

  task automatic t_preset();
    run_check(10);
    check("R9 setup vsync low", {31'd0, vsync}, 0);
    load_mode = 1'b1; host_clr = 1'b1; tick();
    host_clr = 1'b0;
    check("R6 load black", {26'd0, red, green, blue}, 0);
    check("R7 clear in load", {13'd0, addr}, 0);
    load_mode = 1'b0; tick();
    check("R9 no clear after load", {13'd0, addr}, 1);
    check("R9 first pixel", {24'd0, pix_now()}, {24'd0, exp_mem[0]});
    tick();
    check("R9 keeps stepping", {13'd0, addr}, 2);
  endtask

  task automatic t_patch();
    load_mode = 1'b1;
    host_clr = 1'b1; tick(); host_clr = 1'b0;
    host_step = 1'b1; repeat (4) tick(); host_step = 1'b0;
    host_we = 1'b1; host_wdata = 8'hE7; tick(); host_we = 1'b0;
    check("R8 write without step", {13'd0, addr}, 4);
    exp_mem[4] = 8'hE7;
    host_clr = 1'b1; tick(); host_clr = 1'b0;
    load_mode = 1'b0;
    enter_run_state();
    run_check(12);
    check("R8 patched byte wrap", {13'd0, addr}, 0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_load_frame();
    t_run_frames();
    t_run_ignore();
    t_preset();
    t_patch();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule